// File: doc/BRIEF.md
# Aligned Mixed-Length Instruction Splitter

This block sits between instruction fetch and decode in a core that runs ordinary 32-bit instructions alongside 64-bit extension instructions. Fetch delivers one naturally aligned 64-bit word per transfer, along with that word's address. The splitter turns each word into instructions for decode. A word holds either two 32-bit instructions, which are issued lower half first, or one 64-bit instruction, which is issued whole. Every issued instruction carries a length tag and its own PC.

The length is read from bits [1:0] of each 32-bit half, because compressed instructions are not supported. The value 2'b11 means a 32-bit instruction. Any other value means the start of a 64-bit instruction. A 64-bit instruction may begin only on an 8-byte boundary, so software pads with a 32-bit NOP (0x00000013) when it would otherwise land in the upper half. If the upper half of a word still carries a 64-bit marker, the splitter raises a one-cycle misalignment fault with that half's PC and drops the half.

Both sides use valid/ready. Decode may stall for any number of cycles. The fetch word is held, and `fw_ready` stays low, until the last instruction taken from the word has been accepted. The path from fetch to decode is combinational. One bit of state records which half is due next.

Top module: `mixlen_splitter`

## Requirements
- R1: After reset, the first instruction presented for a fetch word comes from its lower half at the fetch PC. No fault is raised while no word is offered.
- R2: A half whose bits [1:0] are 2'b11 is issued as a 32-bit instruction. `dv_len64` is 0, and the half appears in `dv_insn[31:0]` with `dv_insn[63:32]` zero. In the lower half, any other value of bits [1:0] (00, 01 or 10) issues the whole fetch word as one 64-bit instruction with `dv_len64` = 1.
- R3: A 64-bit instruction is issued only from a whole fetch word. It is presented once, at the fetch PC, which is 8-byte aligned, and the word is released in the same cycle it is accepted.
- R4: A word that holds two 32-bit instructions issues the lower half at the fetch PC, then the upper half at the fetch PC + 4, in consecutive accepted transfers.
- R5: While `dv_ready` is low, the presented instruction, length tag and PC stay unchanged. `fw_ready` is high only in the cycle in which the last instruction of the word is accepted.
- R6: If the lower half is 32-bit and the upper half has bits [1:0] other than 2'b11, `flt_valid` pulses for exactly the cycle in which the lower half is accepted. In that cycle `flt_pc` = fetch PC + 4 and the word is released. The upper half is never issued, and the next word starts again at its lower half.
- R7: The padding NOP 0x00000013 in an upper half is issued to decode as an ordinary 32-bit instruction at fetch PC + 4.
- R8: The issued PCs advance by 4 after a 32-bit instruction and by 8 after a 64-bit instruction across a stream of consecutive aligned fetch words. `dv_valid` is low whenever `fw_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_valid | input | 1 | Fetch word offered |
| fw_ready | output | 1 | Fetch word fully consumed |
| fw_data | input | 64 | Aligned fetch word, lower half earlier in program order |
| fw_pc | input | PC_W | Address of the fetch word, 8-byte aligned |
| dv_valid | output | 1 | Instruction offered to decode |
| dv_ready | input | 1 | Decode accepts the instruction |
| dv_insn | output | 64 | Instruction bits, zero-extended when 32-bit |
| dv_len64 | output | 1 | 1 for a 64-bit instruction, 0 for 32-bit |
| dv_pc | output | PC_W | PC of the presented instruction |
| flt_valid | output | 1 | One-cycle misalignment fault pulse |
| flt_pc | output | PC_W | PC of the dropped misaligned half |

## Verification
The bound checker tests several properties on every cycle:
- 64-bit issues fall on aligned PCs.
- Each tag agrees with the marker bits of the issued word.
- A stalled output holds steady.
- The upper half follows the lower half exactly 4 bytes later.
- A fault always names an upper-half PC and releases the word.
- A word is released only on an accepted transfer.

Some behaviour can only be shown by the bench's directed scenarios, because it needs expected data worked out from known stimulus. This covers the actual instruction bits and their order, that all three non-11 markers are treated as 64-bit, that a faulting upper half never reaches decode, that the NOP pad passes through, and that PCs progress correctly across a stream of mixed words.

// File: rtl/mixlen_splitter.sv
module mixlen_splitter #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fw_valid,
  output logic            fw_ready,
  input  logic [63:0]     fw_data,
  input  logic [PC_W-1:0] fw_pc,
  output logic            dv_valid,
  input  logic            dv_ready,
  output logic [63:0]     dv_insn,
  output logic            dv_len64,
  output logic [PC_W-1:0] dv_pc,
  output logic            flt_valid,
  output logic [PC_W-1:0] flt_pc
);

  localparam logic [1:0] MARK32 = 2'b11;

  logic hi_sel;
  logic lo_is32, hi_is32, last, take;

  assign lo_is32 = fw_data[1:0]   == MARK32;
  assign hi_is32 = fw_data[33:32] == MARK32;

  assign last = hi_sel | ~lo_is32 | ~hi_is32;
  assign take = fw_valid & dv_ready;

  assign dv_valid = fw_valid;
  assign dv_len64 = ~hi_sel & ~lo_is32;
  assign dv_pc    = fw_pc + (hi_sel ? PC_W'(4) : PC_W'(0));

  always_comb begin
    if (hi_sel)       dv_insn = {32'h0, fw_data[63:32]};
    else if (lo_is32) dv_insn = {32'h0, fw_data[31:0]};
    else              dv_insn = fw_data;
  end

  assign fw_ready  = dv_ready & last;
  assign flt_valid = take & ~hi_sel & lo_is32 & ~hi_is32;
  assign flt_pc    = fw_pc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n)    hi_sel <= 1'b0;
    else if (take) hi_sel <= ~last;
  end

endmodule

// File: rtl/mixlen_splitter_chk.sv
module mixlen_splitter_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fw_valid,
  input logic            fw_ready,
  input logic            dv_valid,
  input logic            dv_ready,
  input logic [63:0]     dv_insn,
  input logic            dv_len64,
  input logic [PC_W-1:0] dv_pc,
  input logic            flt_valid,
  input logic [PC_W-1:0] flt_pc
);

  p_aligned64_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_valid && dv_len64) |-> (dv_pc[2:0] == 3'b000 && fw_ready == dv_ready));

  p_tag_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid |-> (dv_len64 ? (dv_insn[1:0] != 2'b11)
                           : (dv_insn[1:0] == 2'b11 && dv_insn[63:32] == 32'h0)));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_valid && !dv_ready) |=> ($stable(dv_insn) && $stable(dv_pc) && $stable(dv_len64)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_ready) |-> (dv_valid && dv_ready));

  p_upper_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_valid && dv_ready && !fw_ready) |=> (dv_pc == $past(dv_pc) + PC_W'(4) && !dv_len64));

  p_fault_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (flt_pc[2:0] == 3'b100 && fw_ready && !dv_len64));

  p_no_fault_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_valid |-> (!flt_valid && !dv_valid));

endmodule

bind mixlen_splitter mixlen_splitter_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_ready(fw_ready),
  .dv_valid(dv_valid), .dv_ready(dv_ready), .dv_insn(dv_insn),
  .dv_len64(dv_len64), .dv_pc(dv_pc), .flt_valid(flt_valid), .flt_pc(flt_pc)
);

// File: tb/mixlen_splitter_tb.sv
module mixlen_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fw_valid = 1'b0;
  logic            fw_ready;
  logic [63:0]     fw_data = '0;
  logic [PC_W-1:0] fw_pc = '0;
  logic            dv_valid;
  logic            dv_ready = 1'b0;
  logic [63:0]     dv_insn;
  logic            dv_len64;
  logic [PC_W-1:0] dv_pc;
  logic            flt_valid;
  logic [PC_W-1:0] flt_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixlen_splitter #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_ready(fw_ready),
    .fw_data(fw_data), .fw_pc(fw_pc), .dv_valid(dv_valid), .dv_ready(dv_ready),
    .dv_insn(dv_insn), .dv_len64(dv_len64), .dv_pc(dv_pc),
    .flt_valid(flt_valid), .flt_pc(flt_pc)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [63:0] d, input logic [PC_W-1:0] pc, input bit rdy);
    @(negedge clk);
    fw_valid = v; fw_data = d; fw_pc = pc; dv_ready = rdy;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [63:0] insn, input bit l64,
                            input logic [PC_W-1:0] pc, input bit frdy, input bit flt);
    chk(dv_valid == 1'b1, {req, " valid"}, 64'(dv_valid), 64'd1);
    chk(dv_insn == insn, {req, " insn"}, dv_insn, insn);
    chk(dv_len64 == l64, {req, " len64"}, 64'(dv_len64), 64'(l64));
    chk(dv_pc == pc, {req, " pc"}, 64'(dv_pc), 64'(pc));
    chk(fw_ready == frdy, {req, " fw_ready"}, 64'(fw_ready), 64'(frdy));
    chk(flt_valid == flt, {req, " flt_valid"}, 64'(flt_valid), 64'(flt));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, '0, '0, 1);
    chk(dv_valid == 0 && flt_valid == 0, "R1 idle after reset", {62'h0, dv_valid, flt_valid}, 64'h0);
    chk(dv_valid == 0, "R8 no valid without fetch", 64'(dv_valid), 64'h0);
    drive(1, 64'h00b00113_00a00093, 32'h40, 1);
    expect_out("R1 first from lower half", 64'h00a00093, 0, 32'h40, 0, 0);
    drive(1, 64'h00b00113_00a00093, 32'h40, 1);
    drive(0, '0, '0, 0);
  endtask

  task automatic t_pair;
    drive(1, 64'h002081b3_40208233, 32'h100, 1);
    expect_out("R4 lower first", 64'h40208233, 0, 32'h100, 0, 0);
    drive(1, 64'h002081b3_40208233, 32'h100, 1);
    expect_out("R4 upper second", 64'h002081b3, 0, 32'h104, 1, 0);
    drive(0, '0, '0, 0);
  endtask

  task automatic t_wide;
    logic [63:0] w [3];
    w[0] = 64'h12345678_9abcdef0;
    w[1] = 64'hcafef00d_00001231;
    w[2] = 64'h0badf00d_7777aaa2;
    for (int i = 0; i < 3; i++) begin
      drive(1, w[i], 32'h200 + 32'(i*8), 1);
      expect_out("R2 R3 wide word", w[i], 1, 32'h200 + 32'(i*8), 1, 0);
    end
    drive(0, '0, '0, 0);
  endtask

  task automatic t_stall;
    drive(1, 64'h00c00193_00d00213, 32'h300, 0);
    expect_out("R5 stall lower", 64'h00d00213, 0, 32'h300, 0, 0);
    drive(1, 64'h00c00193_00d00213, 32'h300, 0);
    expect_out("R5 stall lower held", 64'h00d00213, 0, 32'h300, 0, 0);
    drive(1, 64'h00c00193_00d00213, 32'h300, 1);
    expect_out("R5 lower taken", 64'h00d00213, 0, 32'h300, 0, 0);
    drive(1, 64'h00c00193_00d00213, 32'h300, 0);
    expect_out("R5 stall upper held", 64'h00c00193, 0, 32'h304, 0, 0);
    drive(1, 64'h00c00193_00d00213, 32'h300, 1);
    expect_out("R5 upper release", 64'h00c00193, 0, 32'h304, 1, 0);
    drive(0, '0, '0, 0);
  endtask

  task automatic t_fault;
    drive(1, 64'h55555556_00e00293, 32'h400, 0);
    expect_out("R6 no fault while stalled", 64'h00e00293, 0, 32'h400, 0, 0);
    drive(1, 64'h55555556_00e00293, 32'h400, 1);
    expect_out("R6 fault pulse", 64'h00e00293, 0, 32'h400, 1, 1);
    chk(flt_pc == 32'h404, "R6 fault pc", 64'(flt_pc), 64'h404);
    drive(1, 64'h00f00313_01000393, 32'h408, 1);
    expect_out("R6 next word from lower, upper dropped", 64'h01000393, 0, 32'h408, 0, 0);
    drive(1, 64'h00f00313_01000393, 32'h408, 1);
    expect_out("R6 next word upper", 64'h00f00313, 0, 32'h40c, 1, 0);
    drive(0, '0, '0, 0);
  endtask

  task automatic t_pad;
    drive(1, 64'h00000013_01100413, 32'h500, 1);
    expect_out("R8 stream 32-bit", 64'h01100413, 0, 32'h500, 0, 0);
    drive(1, 64'h00000013_01100413, 32'h500, 1);
    expect_out("R7 nop pad", 64'h00000013, 0, 32'h504, 1, 0);
    drive(1, 64'h0000abcd_1234567c, 32'h508, 1);
    expect_out("R8 stream 64-bit after pad", 64'h0000abcd_1234567c, 1, 32'h508, 1, 0);
    drive(1, 64'h01200493_01300513, 32'h510, 1);
    expect_out("R8 stream after 64-bit", 64'h01300513, 0, 32'h510, 0, 0);
    drive(1, 64'h01200493_01300513, 32'h510, 1);
    drive(0, '0, '0, 0);
  endtask

  initial begin
    t_reset();
    t_pair();
    t_wide();
    t_stall();
    t_fault();
    t_pad();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule